// File: doc/BRIEF.md
# Humidity and Temperature Sensor I2C Register Target

This block is the two-wire-bus face of a small humidity and temperature sensor. It watches the serial clock and data lines and answers its 7-bit device address. The first byte written after the address sets a register pointer. Later bytes write through that pointer or read from it. A set top bit in the pointer byte makes the pointer step after every data byte, so one transfer can cover a run of registers. Without that bit, every byte of the transfer uses the same register.

Behind the pointer sit these registers: a fixed identity byte, an averaging-depth setting, three control registers, a sample-status byte, two little-endian 16-bit result pairs (humidity and temperature) and sixteen read-only calibration bytes. Samples arrive on parallel inputs with one-cycle valid strobes. The control fields go out as plain configuration outputs to the measuring front end. Start-conversion and reload requests are bits that stay set until the front end signals completion. A data-ready pin reports unread samples, with a selectable enable, polarity and drive type. A block-update mode keeps the two bytes of a result pair from coming from different samples.

Top module: `sens_i2c_regbank`

## Requirements
- R1: The target acknowledges only 7-bit address 0x5F (write byte 0xBE, read byte 0xBF). For any other address it leaves SDA released, and it always releases SDA after a stop condition.
- R2: Register 0x0F always reads 0xBC.
- R3: The pointer byte sets the register pointer from its bits 6:0. When its bit 7 is 1, the pointer steps by one after each data byte written or read. When bit 7 is 0, every byte of the transfer uses the same register.
- R4: These registers are read/write with the following bit masks (unused bits read 0):
  - 0x10 uses mask 0x3F: bits 2:0 drive `avg_h_o` and bits 5:3 drive `avg_t_o`.
  - 0x20 uses mask 0x87: bit 7 drives `pwr_o`, bit 2 is block update, bits 1:0 drive `odr_o`.
  - 0x21 uses mask 0x83: bit 1 drives `heater_o`.
  - 0x22 uses mask 0xC4.
- R5: The humidity sample reads at 0x28 (bits 7:0) and 0x29 (bits 15:8). The temperature sample reads at 0x2A (bits 7:0) and 0x2B (bits 15:8).
- R6: When bit 2 of 0x20 is 1, reading either byte of a result pair freezes that pair. It unfreezes only when the other byte is read. Samples that arrive meanwhile become visible after the unfreeze.
- R7: When bit 2 of 0x20 is 0, both bytes of a pair always show the newest captured sample.
- R8: Register 0x27 shows humidity-available in bit 1 and temperature-available in bit 0. Each bit sets when a sample is captured and clears when the high byte of its pair (0x29 or 0x2B) is read.
- R9: In 0x21, bit 0 (start conversion, `oneshot_o`) clears on `conv_done_i`, and bit 7 (reload, `boot_o`) clears on `boot_done_i`.
- R10: The data-ready condition is bit 2 of 0x22 AND (either available bit set). Bit 7 of 0x22 = 1 makes the pin active low. Bit 6 of 0x22 = 0 gives push-pull (`drdy_oe_o`=1, `drdy_o`=level). Bit 6 = 1 gives open drain (`drdy_o`=0, `drdy_oe_o`=1 exactly when the level is low).
- R11: Registers 0x30..0x3F read calibration byte n = `cal_i[8n+7:8n]`.
- R12: Writes to read-only or unmapped registers are acknowledged and change nothing. Unmapped registers read 0x00. While bit 7 of 0x20 is 0, sample strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| hum_i | input | 16 | Humidity sample |
| hum_vld_i | input | 1 | Humidity sample strobe |
| tmp_i | input | 16 | Temperature sample |
| tmp_vld_i | input | 1 | Temperature sample strobe |
| cal_i | input | 128 | Calibration bytes, byte n at bits 8n+7:8n |
| conv_done_i | input | 1 | Conversion finished, clears start-conversion bit |
| boot_done_i | input | 1 | Reload finished, clears reload bit |
| pwr_o | output | 1 | Device active |
| odr_o | output | 2 | Output rate code |
| avg_h_o | output | 3 | Humidity averaging code |
| avg_t_o | output | 3 | Temperature averaging code |
| heater_o | output | 1 | Heater enable |
| oneshot_o | output | 1 | Start-conversion request |
| boot_o | output | 1 | Reload request |
| drdy_o | output | 1 | Data-ready pin level |
| drdy_oe_o | output | 1 | Data-ready pin drive enable |

## Verification
The assertions check these rules on every cycle:
- the bus is released after a stop and after a foreign address;
- the pointer steps by exactly one per data byte in increment mode;
- a completion pulse clears the start-conversion bit;
- a frozen pair holds steady while no read touches it;
- every capture raises the available flag;
- an uncaptured strobe leaves the live sample alone.

Other behaviour shows only in the bench's bus scenarios:
- byte ordering within a transfer;
- write masks;
- unfreeze ordering in both read orders;
- every combination of data-ready polarity and drive type;
- a sweep of all 128 register addresses against a model.

// File: rtl/sens_i2c_pkg.sv
package sens_i2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK
  } i2c_st_e;

  localparam logic [6:0] A_ID   = 7'h0F;
  localparam logic [6:0] A_AVG  = 7'h10;
  localparam logic [6:0] A_C1   = 7'h20;
  localparam logic [6:0] A_C2   = 7'h21;
  localparam logic [6:0] A_C3   = 7'h22;
  localparam logic [6:0] A_STAT = 7'h27;
  localparam logic [6:0] A_HLO  = 7'h28;

  localparam logic [7:0] M_AVG = 8'h3F;
  localparam logic [7:0] M_C1  = 8'h87;
  localparam logic [7:0] M_C2  = 8'h83;
  localparam logic [7:0] M_C3  = 8'hC4;

  localparam int CAL_BYTES = 16;
  localparam int NCH       = 2;
endpackage

// File: rtl/sens_i2c_sync.sv
module sens_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '1;
    else         sh <= {sh[STAGES-1:0], d_i};
  end

  assign q_o    = sh[STAGES-1];
  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/sens_i2c_engine.sv
module sens_i2c_engine
  import sens_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       sub_stb_o,
  output logic       wr_stb_o,
  output logic       rd_stb_o,
  output logic [7:0] byte_o
);
  i2c_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sh, txsh;
  logic       rw, sub_ph, nack;

  logic start, stop, byte_end;
  assign start    = sda_fall_i & scl_i;
  assign stop     = sda_rise_i & scl_i;
  assign byte_end = scl_fall_i & (cnt == 4'd8);

  assign sub_stb_o = (st == S_RX) & byte_end & sub_ph;
  assign wr_stb_o  = (st == S_RX) & byte_end & ~sub_ph;
  assign rd_stb_o  = ((st == S_AACK) & scl_fall_i & rw) |
                     ((st == S_TACK) & scl_fall_i & ~nack);
  assign byte_o    = sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; txsh <= '0;
      rw <= 1'b0; sub_ph <= 1'b0; nack <= 1'b0; sda_oe_o <= 1'b0;
    end else if (start) begin
      st <= S_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_oe_o <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR: begin
          if (scl_rise_i) begin
            sh <= {sh[6:0], sda_i}; cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (sh[7:1] == DEV_ADDR) begin
              st <= S_AACK; sda_oe_o <= 1'b1; rw <= sh[0];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall_i) begin
          if (rw) begin
            st <= S_TX; txsh <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
          end else begin
            st <= S_RX; sda_oe_o <= 1'b0; sub_ph <= 1'b1;
          end
        end
        S_RX: begin
          if (scl_rise_i) begin
            sh <= {sh[6:0], sda_i}; cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0; st <= S_RACK; sda_oe_o <= 1'b1;
          end
        end
        S_RACK: if (scl_fall_i) begin
          st <= S_RX; sda_oe_o <= 1'b0; sub_ph <= 1'b0;
        end
        S_TX: begin
          if (scl_rise_i) cnt <= cnt + 4'd1;
          else if (byte_end) begin
            cnt <= '0; st <= S_TACK; sda_oe_o <= 1'b0;
          end else if (scl_fall_i) begin
            txsh <= {txsh[6:0], 1'b0}; sda_oe_o <= ~txsh[6];
          end
        end
        S_TACK: begin
          if (scl_rise_i) nack <= sda_i;
          else if (scl_fall_i) begin
            if (nack) st <= S_IDLE;
            else begin
              st <= S_TX; txsh <= rd_data_i; sda_oe_o <= ~rd_data_i[7];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_release_on_stop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !start) |=> !sda_oe_o);
  assert_foreign_nack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_ADDR && byte_end && !start && !stop && sh[7:1] != DEV_ADDR) |=> !sda_oe_o);
endmodule

// File: rtl/sens_out_pair.sv
module sens_out_pair #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] din_i,
  input  logic         bdu_i,
  input  logic         rd_lo_i,
  input  logic         rd_hi_i,
  output logic [W-1:0] val_o,
  output logic         avail_o
);
  logic [W-1:0] live, frozen;
  logic         lock, lo_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live <= '0; frozen <= '0; lock <= 1'b0; lo_first <= 1'b0; avail_o <= 1'b0;
    end else begin
      if (cap_i) live <= din_i;
      if (!bdu_i) lock <= 1'b0;
      else if (rd_lo_i | rd_hi_i) begin
        if (!lock) begin
          lock <= 1'b1; frozen <= live; lo_first <= rd_lo_i;
        end else if ((lo_first & rd_hi_i) | (~lo_first & rd_lo_i)) begin
          lock <= 1'b0;
        end
      end
      if (cap_i)        avail_o <= 1'b1;
      else if (rd_hi_i) avail_o <= 1'b0;
    end
  end

  assign val_o = lock ? frozen : live;

  assert_freeze_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && bdu_i && !rd_lo_i && !rd_hi_i) |=> $stable(val_o));
  assert_avail_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> avail_o);
  assert_no_capture_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(live));
endmodule

// File: rtl/sens_regfile.sv
module sens_regfile
  import sens_i2c_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'hBC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sub_stb_i,
  input  logic                   wr_stb_i,
  input  logic                   rd_stb_i,
  input  logic [7:0]             byte_i,
  output logic [7:0]             rd_data_o,
  input  logic [15:0]            hum_i,
  input  logic                   hum_vld_i,
  input  logic [15:0]            tmp_i,
  input  logic                   tmp_vld_i,
  input  logic [8*CAL_BYTES-1:0] cal_i,
  input  logic                   conv_done_i,
  input  logic                   boot_done_i,
  output logic                   pwr_o,
  output logic [1:0]             odr_o,
  output logic [2:0]             avg_h_o,
  output logic [2:0]             avg_t_o,
  output logic                   heater_o,
  output logic                   oneshot_o,
  output logic                   boot_o,
  output logic                   drdy_o,
  output logic                   drdy_oe_o
);
  logic [6:0] ptr;
  logic       inc;
  logic [7:0] avg, c1, c2, c3;

  logic [15:0] din [NCH];
  logic [15:0] val [NCH];
  logic        vld [NCH];
  logic [NCH-1:0] av;

  assign din[0] = hum_i;
  assign din[1] = tmp_i;
  assign vld[0] = hum_vld_i;
  assign vld[1] = tmp_vld_i;

  // channel 0 humidity at 0x28/0x29, channel 1 temperature at 0x2A/0x2B
  for (genvar c = 0; c < NCH; c++) begin : g_pair
    localparam logic [6:0] LO = A_HLO + 7'(2 * c);
    sens_out_pair #(.W(16)) u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (vld[c] & c1[7]),
      .din_i   (din[c]),
      .bdu_i   (c1[2]),
      .rd_lo_i (rd_stb_i && ptr == LO),
      .rd_hi_i (rd_stb_i && ptr == LO + 7'd1),
      .val_o   (val[c]),
      .avail_o (av[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr <= '0; inc <= 1'b0;
    end else if (sub_stb_i) begin
      ptr <= byte_i[6:0]; inc <= byte_i[7];
    end else if ((rd_stb_i | wr_stb_i) & inc) begin
      ptr <= ptr + 7'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg <= '0; c1 <= '0; c2 <= '0; c3 <= '0;
    end else begin
      if (conv_done_i) c2[0] <= 1'b0;
      if (boot_done_i) c2[7] <= 1'b0;
      if (wr_stb_i) begin
        unique case (ptr)
          A_AVG:   avg <= byte_i & M_AVG;
          A_C1:    c1  <= byte_i & M_C1;
          A_C2:    c2  <= byte_i & M_C2;
          A_C3:    c3  <= byte_i & M_C3;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (ptr[6:4] == 3'b011) rd_data_o = cal_i[{ptr[3:0], 3'b000} +: 8];
    else begin
      unique case (ptr)
        A_ID:         rd_data_o = ID_VALUE;
        A_AVG:        rd_data_o = avg;
        A_C1:         rd_data_o = c1;
        A_C2:         rd_data_o = c2;
        A_C3:         rd_data_o = c3;
        A_STAT:       rd_data_o = {6'b0, av[0], av[1]};
        A_HLO:        rd_data_o = val[0][7:0];
        A_HLO + 7'd1: rd_data_o = val[0][15:8];
        A_HLO + 7'd2: rd_data_o = val[1][7:0];
        A_HLO + 7'd3: rd_data_o = val[1][15:8];
        default:      rd_data_o = 8'h00;
      endcase
    end
  end

  logic act, lvl;
  assign act = c3[2] & (|av);
  assign lvl = c3[7] ? ~act : act;
  assign drdy_o    = c3[6] ? 1'b0 : lvl;
  assign drdy_oe_o = c3[6] ? ~lvl : 1'b1;

  assign pwr_o     = c1[7];
  assign odr_o     = c1[1:0];
  assign avg_h_o   = avg[2:0];
  assign avg_t_o   = avg[5:3];
  assign heater_o  = c2[1];
  assign oneshot_o = c2[0];
  assign boot_o    = c2[7];

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_stb_i || wr_stb_i) && inc && !sub_stb_i) |=> ptr == $past(ptr) + 7'd1);
  assert_oneshot_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !(wr_stb_i && ptr == A_C2)) |=> !oneshot_o);
endmodule

// File: rtl/sens_i2c_regbank.sv
module sens_i2c_regbank
  import sens_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5F,
  parameter logic [7:0] ID_VALUE    = 8'hBC,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [15:0]            hum_i,
  input  logic                   hum_vld_i,
  input  logic [15:0]            tmp_i,
  input  logic                   tmp_vld_i,
  input  logic [8*CAL_BYTES-1:0] cal_i,
  input  logic                   conv_done_i,
  input  logic                   boot_done_i,
  output logic                   pwr_o,
  output logic [1:0]             odr_o,
  output logic [2:0]             avg_h_o,
  output logic [2:0]             avg_t_o,
  output logic                   heater_o,
  output logic                   oneshot_o,
  output logic                   boot_o,
  output logic                   drdy_o,
  output logic                   drdy_oe_o
);
  logic scl_q, scl_r, scl_f, sda_q, sda_r, sda_f;
  logic sub_stb, wr_stb, rd_stb;
  logic [7:0] bus_byte, rd_data;

  sens_i2c_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i),
    .q_o(scl_q), .rise_o(scl_r), .fall_o(scl_f));

  sens_i2c_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i),
    .q_o(sda_q), .rise_o(sda_r), .fall_o(sda_f));

  sens_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_i(scl_q), .scl_rise_i(scl_r), .scl_fall_i(scl_f),
    .sda_i(sda_q), .sda_rise_i(sda_r), .sda_fall_i(sda_f),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
    .sub_stb_o(sub_stb), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
    .byte_o(bus_byte));

  sens_regfile #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sub_stb_i(sub_stb), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb),
    .byte_i(bus_byte), .rd_data_o(rd_data),
    .hum_i(hum_i), .hum_vld_i(hum_vld_i), .tmp_i(tmp_i), .tmp_vld_i(tmp_vld_i),
    .cal_i(cal_i), .conv_done_i(conv_done_i), .boot_done_i(boot_done_i),
    .pwr_o(pwr_o), .odr_o(odr_o), .avg_h_o(avg_h_o), .avg_t_o(avg_t_o),
    .heater_o(heater_o), .oneshot_o(oneshot_o), .boot_o(boot_o),
    .drdy_o(drdy_o), .drdy_oe_o(drdy_oe_o));
endmodule

// File: tb/tb_sens_i2c_regbank.sv
`timescale 1ns/1ps
module tb_sens_i2c_regbank;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [15:0] hum = '0, tmp = '0;
  logic hum_vld = 1'b0, tmp_vld = 1'b0;
  logic [127:0] cal;
  logic conv_done = 1'b0, boot_done = 1'b0;
  logic pwr, heater, oneshot, boot, drdy, drdy_oe;
  logic [1:0] odr;
  logic [2:0] avg_h, avg_t;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  sens_i2c_regbank dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .hum_i(hum), .hum_vld_i(hum_vld), .tmp_i(tmp), .tmp_vld_i(tmp_vld), .cal_i(cal),
    .conv_done_i(conv_done), .boot_done_i(boot_done), .pwr_o(pwr), .odr_o(odr),
    .avg_h_o(avg_h), .avg_t_o(avg_t), .heater_o(heater), .oneshot_o(oneshot),
    .boot_o(boot), .drdy_o(drdy), .drdy_oe_o(drdy_oe));

  int n_chk = 0, n_err = 0, ack_miss = 0;
  logic [7:0] rbuf [16];
  logic [7:0] m_avg, m_c1, m_c2, m_c3;
  logic [15:0] m_h, m_t;
  logic m_hav, m_tav;

  function automatic logic [7:0] cal_byte(input int n);
    logic [7:0] t;
    t = 8'(n * 37 + 5);
    return t ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a >= 'h30 && a <= 'h3F) return cal_byte(a - 'h30);
    case (a)
      'h0F: return 8'hBC;
      'h10: return m_avg;
      'h20: return m_c1;
      'h21: return m_c2;
      'h22: return m_c3;
      'h27: return {6'b0, m_hav, m_tav};
      'h28: return m_h[7:0];
      'h29: return m_h[15:8];
      'h2A: return m_t[7:0];
      'h2B: return m_t[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); v[i] = r; end
    bit_io(last, r);
  endtask

  task automatic reg_wr(input logic [7:0] sub, input logic [7:0] d0, d1, d2, input int n);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start;
    wr_byte(8'hBE, a); if (!a) ack_miss++;
    wr_byte(sub, a);   if (!a) ack_miss++;
    for (int i = 0; i < n; i++) begin wr_byte(d[i], a); if (!a) ack_miss++; end
    bus_stop;
  endtask

  task automatic reg_rd(input logic [7:0] sub, input int n);
    logic a;
    bus_start;
    wr_byte(8'hBE, a); if (!a) ack_miss++;
    wr_byte(sub, a);   if (!a) ack_miss++;
    bus_start;
    wr_byte(8'hBF, a); if (!a) ack_miss++;
    for (int i = 0; i < n; i++) rd_byte(i == n - 1, rbuf[i]);
    bus_stop;
  endtask

  task automatic feed(input logic ch, input logic [15:0] v);
    if (ch) begin tmp = v; tmp_vld = 1'b1; end
    else    begin hum = v; hum_vld = 1'b1; end
    tick(1);
    hum_vld = 1'b0; tmp_vld = 1'b0;
    tick(2);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end

  initial begin
    logic a;
    for (int n = 0; n < 16; n++) cal[8*n +: 8] = cal_byte(n);
    tick(5); rst_ni = 1'b1; tick(5);

    // reset state
    chk("R1 reset sda released", sda_oe, 0);
    chk("R4 reset pwr", pwr, 0);
    chk("R10 reset drdy push-pull inactive", {drdy, drdy_oe}, 2'b01);

    // R1 address decode
    bus_start; wr_byte(8'hA0, a); bus_stop;
    chk("R1 foreign address nack", a, 0);
    bus_start; wr_byte(8'hBC, a); bus_stop;
    chk("R1 neighbour address 0x5E nack", a, 0);
    bus_start; wr_byte(8'hBE, a); bus_stop;
    chk("R1 own address ack", a, 1);
    chk("R1 released after stop", sda_oe, 0);

    // R2 identity, R12 write ignored
    reg_rd(8'h0F, 1); chk("R2 id", rbuf[0], 8'hBC);
    reg_wr(8'h0F, 8'h55, 0, 0, 1);
    reg_rd(8'h0F, 1); chk("R12 id after write", rbuf[0], 8'hBC);

    // R4 masks and field outputs
    reg_wr(8'h10, 8'hFF, 0, 0, 1);
    reg_rd(8'h10, 1); chk("R4 avg mask", rbuf[0], 8'h3F);
    chk("R4 avg fields", {avg_t, avg_h}, 6'o77);
    reg_wr(8'h10, 8'h1A, 0, 0, 1);
    chk("R4 avg fields 0x1A", {avg_t, avg_h}, {3'd3, 3'd2});
    reg_wr(8'h20, 8'hFF, 0, 0, 1);
    reg_rd(8'h20, 1); chk("R4 ctrl1 mask", rbuf[0], 8'h87);
    chk("R4 pwr/odr", {pwr, odr}, 3'b111);
    reg_wr(8'h20, 8'h81, 0, 0, 1);
    chk("R4 odr 01", {pwr, odr}, 3'b101);
    reg_wr(8'h22, 8'hFF, 0, 0, 1);
    reg_rd(8'h22, 1); chk("R4 ctrl3 mask", rbuf[0], 8'hC4);

    // R3 auto increment write and read, then fixed pointer
    reg_wr(8'hA0, 8'h82, 8'h02, 8'h04, 3);
    reg_rd(8'hA0, 3);
    chk("R3 inc read 0x20", rbuf[0], 8'h82);
    chk("R3 inc read 0x21", rbuf[1], 8'h02);
    chk("R3 inc read 0x22", rbuf[2], 8'h04);
    chk("R4 heater", heater, 1);
    reg_wr(8'h22, 8'h00, 8'h04, 0, 2);
    reg_rd(8'h21, 1); chk("R3 fixed pointer left 0x21", rbuf[0], 8'h02);
    reg_rd(8'h22, 1); chk("R3 fixed pointer last wins", rbuf[0], 8'h04);
    reg_rd(8'h0F, 2);
    chk("R3 fixed read byte0", rbuf[0], 8'hBC);
    chk("R3 fixed read byte1", rbuf[1], 8'hBC);

    // R5, R8 samples and status
    reg_wr(8'h20, 8'h80, 0, 0, 1);
    reg_rd(8'h27, 1); chk("R8 status empty", rbuf[0], 8'h00);
    chk("R10 not ready", {drdy, drdy_oe}, 2'b01);
    feed(0, 16'h8123); feed(1, 16'h7FFE);
    reg_rd(8'h27, 1); chk("R8 status both", rbuf[0], 8'h03);
    reg_rd(8'hA8, 4);
    chk("R5 hum lo", rbuf[0], 8'h23);
    chk("R5 hum hi", rbuf[1], 8'h81);
    chk("R5 tmp lo", rbuf[2], 8'hFE);
    chk("R5 tmp hi", rbuf[3], 8'h7F);
    reg_rd(8'h27, 1); chk("R8 status cleared by high reads", rbuf[0], 8'h00);
    feed(1, 16'h0001);
    reg_rd(8'h27, 1); chk("R8 temp bit0 only", rbuf[0], 8'h01);
    reg_rd(8'h2A, 1);
    reg_rd(8'h27, 1); chk("R8 low read keeps bit", rbuf[0], 8'h01);
    reg_rd(8'h2B, 1);
    reg_rd(8'h27, 1); chk("R8 high read clears", rbuf[0], 8'h00);

    // R10 data-ready pin
    feed(0, 16'h0102);
    reg_wr(8'h22, 8'h04, 0, 0, 1); chk("R10 pp high ready", {drdy, drdy_oe}, 2'b11);
    reg_wr(8'h22, 8'h84, 0, 0, 1); chk("R10 pp low ready", {drdy, drdy_oe}, 2'b01);
    reg_wr(8'h22, 8'h44, 0, 0, 1); chk("R10 od high ready", {drdy, drdy_oe}, 2'b00);
    reg_wr(8'h22, 8'hC4, 0, 0, 1); chk("R10 od low ready", {drdy, drdy_oe}, 2'b01);
    reg_wr(8'h22, 8'h00, 0, 0, 1); chk("R10 disabled", {drdy, drdy_oe}, 2'b01);
    reg_wr(8'h22, 8'h40, 0, 0, 1); chk("R10 od disabled", {drdy, drdy_oe}, 2'b01);
    reg_wr(8'h22, 8'hC4, 0, 0, 1);
    reg_rd(8'h29, 1);
    chk("R10 od low not ready", {drdy, drdy_oe}, 2'b00);

    // R6 block update
    reg_wr(8'h20, 8'h84, 0, 0, 1);
    feed(0, 16'h1234);
    reg_rd(8'h28, 1); chk("R6 lo before freeze", rbuf[0], 8'h34);
    feed(0, 16'h5678);
    reg_rd(8'h29, 1); chk("R6 hi frozen", rbuf[0], 8'h12);
    reg_rd(8'hA8, 2);
    chk("R6 new lo after unfreeze", rbuf[0], 8'h78);
    chk("R6 new hi after unfreeze", rbuf[1], 8'h56);
    feed(1, 16'h1111);
    reg_rd(8'h2B, 1); chk("R6 hi first", rbuf[0], 8'h11);
    feed(1, 16'h2222);
    reg_rd(8'h2B, 1); chk("R6 hi again still frozen", rbuf[0], 8'h11);
    reg_rd(8'h2A, 1); chk("R6 lo frozen releases", rbuf[0], 8'h11);
    reg_rd(8'h2A, 1); chk("R6 lo after release", rbuf[0], 8'h22);

    // R7 continuous update
    reg_wr(8'h20, 8'h80, 0, 0, 1);
    feed(0, 16'h1234);
    reg_rd(8'h28, 1); chk("R7 lo", rbuf[0], 8'h34);
    feed(0, 16'hABCD);
    reg_rd(8'h29, 1); chk("R7 hi follows new sample", rbuf[0], 8'hAB);

    // R9 self-clearing bits
    reg_wr(8'h21, 8'h83, 0, 0, 1);
    chk("R9 requests set", {boot, heater, oneshot}, 3'b111);
    conv_done = 1'b1; tick(1); conv_done = 1'b0;
    chk("R9 oneshot cleared", {boot, oneshot}, 2'b10);
    reg_rd(8'h21, 1); chk("R9 ctrl2 after conv", rbuf[0], 8'h82);
    boot_done = 1'b1; tick(1); boot_done = 1'b0;
    chk("R9 boot cleared", boot, 0);
    reg_rd(8'h21, 1); chk("R9 ctrl2 after boot", rbuf[0], 8'h02);

    // R12 power off and read-only writes
    reg_wr(8'h20, 8'h00, 0, 0, 1);
    feed(0, 16'h0F0F);
    reg_rd(8'hA8, 2);
    chk("R12 no capture lo", rbuf[0], 8'hCD);
    chk("R12 no capture hi", rbuf[1], 8'hAB);
    reg_rd(8'h27, 1); chk("R12 no status when off", rbuf[0], 8'h00);
    reg_wr(8'hA7, 8'hFF, 8'h00, 8'h00, 3);
    reg_rd(8'hA7, 3);
    chk("R12 status write ignored", rbuf[0], 8'h00);
    chk("R12 out lo write ignored", rbuf[1], 8'hCD);
    chk("R12 out hi write ignored", rbuf[2], 8'hAB);
    reg_wr(8'h55, 8'h77, 0, 0, 1);
    reg_rd(8'h55, 1); chk("R12 unmapped reads zero", rbuf[0], 8'h00);

    // R11 calibration burst, then full address sweep against model
    reg_wr(8'hA0, 8'h80, 8'h02, 8'h04, 3);
    reg_wr(8'h10, 8'h1A, 0, 0, 1);
    feed(0, 16'h4321); feed(1, 16'h8765);
    reg_rd(8'hB0, 16);
    for (int n = 0; n < 16; n++) chk($sformatf("R11 cal byte %0d", n), rbuf[n], cal_byte(n));
    m_avg = 8'h1A; m_c1 = 8'h80; m_c2 = 8'h02; m_c3 = 8'h04;
    m_h = 16'h4321; m_t = 16'h8765; m_hav = 1'b1; m_tav = 1'b1;
    for (int ad = 0; ad < 128; ad++) begin
      reg_rd(8'(ad), 1);
      chk($sformatf("R12 R11 R5 sweep addr %0h", ad), rbuf[0], exp_rd(ad));
      if (ad == 'h29) m_hav = 1'b0;
      if (ad == 'h2B) m_tav = 1'b0;
    end

    chk("R1 all own transfers acknowledged", ack_miss, 0);
    finish_run;
  end
endmodule